// File: doc/BRIEF.md
# Gated Frequency Counter Controller

This block measures the frequency of a digital signal using a 32.768 kHz reference clock as its only timebase. A binary prescaler divides the reference by 2^DIV_BITS; with the default of 15 bits it produces one tick per second. Each tick advances a ten-state twisted-ring sequencer. The sequencer's phases open a counting window, strobe the result out and then clear the counters, in that order. A full measurement therefore takes ten ticks, and a fresh reading appears every ten seconds.

The measured signal passes through a two-stage synchroniser, and its rising edges are detected in the reference domain. During the window each edge advances a chain of synchronous decimal (BCD) digits. At the strobe phase the digits and an overflow flag are copied into an output register, and a one-cycle valid pulse is raised. The output register keeps that reading while the counters are cleared and the next window runs. Signals must stay below half the reference rate to be measured. A count that would exceed the largest value the digits can show stops at all nines and sets the overflow flag.

Top module: `freq_gate_meter`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `result_bcd` is zero and `result_ovf` and `result_valid` are 0.
- R2: Edges are counted only while the sequencer is in its first phase. That phase lasts exactly 2^DIV_BITS reference cycles. With reset released at edge 0, counter increments at reference edges 10·P·m+1 through 10·P·m+P take effect, where P = 2^DIV_BITS and m is the measurement number.
- R3: Each rising edge of `sig_in` adds one to the count, whatever its high width. A rising edge sampled at reference edge k causes an increment at edge k+2.
- R4: Rising edges whose increment would fall outside the window do not change the result.
- R5: `result_valid` is high for exactly one cycle, after reference edge 10·P·m+2·P+1, and `result_bcd` takes the new reading at that same edge.
- R6: `result_bcd` holds DIGITS decimal digits, 4 bits each, with the least significant digit in bits [3:0] and digit i in bits [4i+3:4i]. No digit ever exceeds 9.
- R7: Between strobes, `result_bcd` and `result_ovf` keep their value, including while the counters are cleared and the next window is counting.
- R8: If more edges arrive than 10^DIGITS−1, the reading is 10^DIGITS−1 and `result_ovf` is 1. A reading of exactly 10^DIGITS−1 edges has `result_ovf` 0.
- R9: The counters are cleared in the fifth phase, so every reading counts only its own window, and an overflow does not carry into the next reading.
- R10: The sequencer steps through exactly ten legal patterns, one per tick. Any illegal pattern is forced to all zeros, which is the legal start pattern, so the result period is always 10·P cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock (32.768 kHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Signal to be measured, asynchronous |
| result_bcd | output | 4*DIGITS | Latched reading, BCD, least significant digit lowest |
| result_ovf | output | 1 | Latched overflow flag for the reading |
| result_valid | output | 1 | One-cycle pulse when a new reading is latched |

## Verification
Every result is tied to a reference-edge number counted from reset release. An input rise driven at a cycle boundary increments the count three edges later: two synchroniser stages plus the increment register. The reading and the valid pulse appear one edge after the strobe phase begins, at 2·P+1 within each ten-phase period. The bench keeps its own edge counter and places all stimulus by that counter. It probes the window with rises whose increments fall one edge inside and one edge outside each boundary. It samples the outputs on the falling clock edge at the exact cycles computed above, and also one cycle before and after the strobe.

// File: rtl/fm_pkg.sv
package fm_pkg;
  localparam int SEQ_W  = 5;
  localparam int NPHASE = 2 * SEQ_W;
  typedef logic [SEQ_W-1:0] seq_t;

  // one decimal step, wrapping 9 -> 0
  function automatic logic [3:0] bcd_step(input logic [3:0] d);
    return (d == 4'd9) ? 4'd0 : d + 4'd1;
  endfunction

  // a legal twisted-ring pattern has at most one 0/1 boundary
  function automatic logic seq_legal(input seq_t s);
    int t;
    t = 0;
    for (int i = 0; i < SEQ_W - 1; i++)
      if (s[i] != s[i+1]) t++;
    return (t <= 1);
  endfunction

  // shift with inverted feedback; illegal patterns recover to all zeros
  function automatic seq_t seq_next(input seq_t s);
    if (!seq_legal(s)) return '0;
    return {s[SEQ_W-2:0], ~s[SEQ_W-1]};
  endfunction

  // two-bit decode of each of the ten phases
  function automatic logic [NPHASE-1:0] seq_decode(input seq_t s);
    logic [NPHASE-1:0] d;
    d[0]     = ~s[SEQ_W-1] & ~s[0];
    d[SEQ_W] =  s[SEQ_W-1] &  s[0];
    for (int i = 1; i < SEQ_W; i++) begin
      d[i]         =  s[i-1] & ~s[i];
      d[SEQ_W + i] = ~s[i-1] &  s[i];
    end
    return d;
  endfunction
endpackage

// File: rtl/fm_tick.sv
module fm_tick #(
  parameter int DIV_BITS = 15
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic [DIV_BITS-1:0] cnt;

  assign tick = &cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
endmodule

// File: rtl/fm_seq.sv
module fm_seq
  import fm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output seq_t              state,
  output logic [NPHASE-1:0] phase
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   state <= '0;
    else if (adv) state <= seq_next(state);

  assign phase = seq_decode(state);

  // R10
  seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(state)) else $error("sequencer moved without tick");
endmodule

// File: rtl/fm_edge.sv
module fm_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= 3'b000;
    else        {s1, s2, s3} <= {din, s1, s2};

  assign rise = s2 & ~s3;

  // R3
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise) else $error("edge reported twice");
endmodule

// File: rtl/fm_bcd.sv
module fm_bcd
  import fm_pkg::*;
#(
  parameter int DIGITS = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                inc,
  output logic [4*DIGITS-1:0] val,
  output logic                ovf
);
  logic [DIGITS:0] run;   // run[i]: all digits below i are 9
  logic            full, step;

  assign run[0] = 1'b1;
  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    assign run[g+1] = run[g] & (val[4*g +: 4] == 4'd9);
    // R6
    bcd_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      val[4*g +: 4] <= 4'd9) else $error("digit out of range");
  end

  assign full = run[DIGITS];
  assign step = inc & ~full;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      val <= '0;
      ovf <= 1'b0;
    end else if (clr) begin
      val <= '0;
      ovf <= 1'b0;
    end else begin
      if (step)
        for (int i = 0; i < DIGITS; i++)
          if (run[i]) val[4*i +: 4] <= bcd_step(val[4*i +: 4]);
      if (inc && full) ovf <= 1'b1;
    end

  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && !clr |=> $stable(val)) else $error("count moved past all nines");
  // R4
  count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inc && !clr |=> $stable(val) && $stable(ovf)) else $error("count moved while idle");
endmodule

// File: rtl/freq_gate_meter.sv
module freq_gate_meter
  import fm_pkg::*;
#(
  parameter int DIV_BITS = 15,
  parameter int DIGITS   = 5
) (
  input  logic                clk_ref,
  input  logic                rst_n,
  input  logic                sig_in,
  output logic [4*DIGITS-1:0] result_bcd,
  output logic                result_ovf,
  output logic                result_valid
);
  localparam int CW        = 4 * DIGITS;
  localparam int PH_COUNT  = 0;
  localparam int PH_STROBE = 2;
  localparam int PH_CLEAR  = 4;

  logic              tick, rise, win_en, cnt_clr, strobe_n, strobe_n_q, load;
  seq_t              seq;
  logic [NPHASE-1:0] phase;
  logic [CW-1:0]     cnt_val;
  logic              cnt_ovf;

  fm_tick #(.DIV_BITS(DIV_BITS)) u_tick (.clk(clk_ref), .rst_n(rst_n), .tick(tick));
  fm_seq  u_seq  (.clk(clk_ref), .rst_n(rst_n), .adv(tick), .state(seq), .phase(phase));
  fm_edge u_edge (.clk(clk_ref), .rst_n(rst_n), .din(sig_in), .rise(rise));

  assign win_en   = phase[PH_COUNT];
  assign cnt_clr  = phase[PH_CLEAR];
  assign strobe_n = ~phase[PH_STROBE];

  fm_bcd #(.DIGITS(DIGITS)) u_bcd (
    .clk(clk_ref), .rst_n(rst_n), .clr(cnt_clr), .inc(rise & win_en),
    .val(cnt_val), .ovf(cnt_ovf)
  );

  // falling edge of the active-low strobe loads the display register
  assign load = ~strobe_n & strobe_n_q;

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) begin
      strobe_n_q   <= 1'b1;
      result_bcd   <= '0;
      result_ovf   <= 1'b0;
      result_valid <= 1'b0;
    end else begin
      strobe_n_q   <= strobe_n;
      result_valid <= load;
      if (load) begin
        result_bcd <= cnt_val;
        result_ovf <= cnt_ovf;
      end
    end

  // R10
  seq_onehot_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $countones(phase) == 1) else $error("phase decode not one-hot");
  // R10
  seq_step_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    tick |=> !$stable(seq)) else $error("sequencer missed a tick");
  // R5
  latch_copy_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    result_valid |-> result_bcd == $past(cnt_val)) else $error("reading not copied");
  // R7
  hold_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !load |=> $stable(result_bcd) && $stable(result_ovf)) else $error("reading changed between strobes");
  // R5
  valid_pulse_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    result_valid |=> !result_valid) else $error("valid wider than one cycle");
endmodule

// File: tb/sim_freq_gate_meter.sv
module sim_freq_gate_meter;
  localparam int CLK_T = 10;
  localparam int DIV   = 8;
  localparam int DIG   = 2;
  localparam int P     = 1 << DIV;
  localparam int CYC   = 10 * P;
  localparam int W     = 4 * DIG;

  logic         clk = 1'b0, rst_n = 1'b0, sig = 1'b0;
  logic [W-1:0] bcd;
  logic         ovf, vld;
  int           cyc, checks, errors;
  logic [W-1:0] last_bcd;
  logic         last_ovf;
  bit           done;

  freq_gate_meter #(.DIV_BITS(DIV), .DIGITS(DIG)) u0 (
    .clk_ref(clk), .rst_n(rst_n), .sig_in(sig),
    .result_bcd(bcd), .result_ovf(ovf), .result_valid(vld)
  );

  always #(CLK_T/2) clk = ~clk;

  always @(posedge clk)
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;

  function automatic int max_count();
    int v = 1;
    for (int i = 0; i < DIG; i++) v = v * 10;
    return v - 1;
  endfunction

  function automatic logic [W-1:0] to_bcd(input int n);
    logic [W-1:0] r = '0;
    int v = (n > max_count()) ? max_count() : n;
    for (int i = 0; i < DIG; i++) begin
      r[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic wait_cyc(input int k);
    while (cyc < k) @(negedge clk);
  endtask

  task automatic pulses(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      sig = 1'b1;
      repeat (hi) @(negedge clk);
      sig = 1'b0;
      repeat (lo) @(negedge clk);
    end
  endtask

  // one full ten-phase period; probe adds boundary rises (+2 counted)
  task automatic measure(input int m, input int n_in, input int hi, input int lo,
                         input int n_out, input bit probe);
    int base = m * CYC;
    int exp_n = n_in + (probe ? 2 : 0);
    if (probe) begin
      wait_cyc(base - 4); sig = 1'b1;   // increment at base-1: outside
      @(negedge clk);     sig = 1'b0;
      @(negedge clk);     sig = 1'b1;   // increment at base+1: inside
      @(negedge clk);     sig = 1'b0;
    end
    wait_cyc(base + 8);
    pulses(n_in, hi, lo);
    if (probe) begin
      wait_cyc(base + P - 3); sig = 1'b1; // increment at base+P: inside
      @(negedge clk);         sig = 1'b0;
      @(negedge clk);         sig = 1'b1; // increment at base+P+2: outside
      @(negedge clk);         sig = 1'b0;
    end
    wait_cyc(base + P + 8);
    pulses(n_out, 1, 2);
    wait_cyc(base + 2*P);
    chk("R5 valid early", vld == 1'b0, int'(vld), 0);
    chk("R7 held before strobe", bcd == last_bcd && ovf == last_ovf, int'(bcd), int'(last_bcd));
    wait_cyc(base + 2*P + 1);
    chk("R5 R10 valid due", vld == 1'b1, int'(vld), 1);
    chk("R3 R4 R2 R6 reading", bcd == to_bcd(exp_n), int'(bcd), int'(to_bcd(exp_n)));
    chk("R8 overflow flag", ovf == (exp_n > max_count()), int'(ovf), int'(exp_n > max_count()));
    last_bcd = to_bcd(exp_n);
    last_ovf = (exp_n > max_count());
    wait_cyc(base + 2*P + 2);
    chk("R5 valid one cycle", vld == 1'b0, int'(vld), 0);
    wait_cyc(base + 5*P);
    chk("R7 R9 held across clear", bcd == last_bcd && ovf == last_ovf, int'(bcd), int'(last_bcd));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_T * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    int seed_val, hi, lo, n, no;
    checks = 0; errors = 0; done = 1'b0;
    last_bcd = '0; last_ovf = 1'b0;
    seed_val = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    chk("R1 reset reading", bcd == '0 && ovf == 1'b0 && vld == 1'b0, int'(bcd), 0);
    rst_n = 1'b1;
    chk("R1 released", bcd == '0 && ovf == 1'b0 && vld == 1'b0, int'(bcd), 0);
    measure(0, 5, 1, 1, 0, 1'b0);      // R3 basic
    measure(1, 0, 1, 1, 20, 1'b0);     // R4 edges only outside window
    measure(2, 99, 1, 1, 0, 1'b0);     // R8 exactly full, no overflow
    measure(3, 100, 1, 1, 0, 1'b0);    // R8 one past full
    measure(4, 120, 1, 1, 5, 1'b0);    // R8 saturate
    measure(5, 7, 1, 2, 10, 1'b0);     // R9 overflow cleared
    measure(6, 10, 20, 3, 0, 1'b1);    // R2 boundaries, R3 wide pulses
    for (int m = 7; m < 12; m++) begin
      hi = 1 + int'($urandom_range(2));
      lo = 1 + int'($urandom_range(2));
      n  = int'($urandom_range(240 / (hi + lo)));
      no = int'($urandom_range(40));
      measure(m, n, hi, lo, no, (m % 2) == 1);
    end
    done = 1'b1;
    if (seed_val == 0) seed_val = 1;
    finish_run();
  end
endmodule